// File: doc/BRIEF.md
# Fully Associative Write-Back Data Cache

This block sits between a processor's load/store port and a slower main memory. It holds eight lines of 32 bytes each. Any line of the 32-bit byte address space can be placed in any slot. Each slot keeps a valid flag, a dirty flag and a 27-bit tag, which is the address with its low five bits removed. All eight tags are compared with the request in parallel. A hit is served straight from the stored line. A store that hits changes only the cached copy and marks the slot dirty. Main memory sees the new bytes only when that slot is later chosen as a victim.

On a miss the processor port is held off. The cache picks a slot, using any empty slot first and otherwise the slot named by the replacement state. If the chosen slot is dirty, its eight words go out to memory. The missing line is then read in as eight ascending word beats. After that the original request completes. Store misses allocate: the line is fetched first and the store bytes are merged afterwards. A parameter selects the replacement order. With least-recently-used order, hits refresh a slot. With oldest-fill-first order, only fills change the order.

Top module: `fa_wb_cache`

## Requirements
- R1: After reset every slot is invalid, `cpu_ready` is 1, `cpu_rvalid` is 0 and `mem_req` is 0, so the first access to any line misses.
- R2: A load that hits is accepted when `cpu_valid` and `cpu_ready` are both 1 on a clock edge. `cpu_rvalid` is 1 in the following cycle with the stored word on `cpu_rdata`, and no memory beat takes place.
- R3: A store that hits writes byte lane i (bits 8i+7..8i) only where `cpu_be[i]` is 1. It causes no memory beat. Later loads see the merged word, and memory receives it only when the line is evicted.
- R4: A miss reads the line in eight beats. Beat k uses address {tag, k[2:0], 2'b00}, with k running 0 through 7 in ascending order. A beat completes on a clock edge where `mem_req` and `mem_ack` are both 1. The request is answered after the last beat.
- R5: While any slot is invalid, a miss fills an invalid slot and never evicts a valid line. Eight distinct lines therefore load without any write beat and all stay resident as hits. A line is never held in two slots at once.
- R6: Evicting a slot whose dirty flag is 0 produces no write beat.
- R7: Evicting a dirty slot first writes its eight words to memory at {old tag, k, 2'b00} for k = 0 to 7 in ascending order (`mem_we` = 1). These writes finish before the first read beat of the new line.
- R8: A newly installed line starts clean, even when it replaced a dirty slot, so evicting it without any store produces no write beat.
- R9: With `POLICY` = REPL_LRU (0), a full cache evicts the slot whose last hit or fill is oldest.
- R10: With `POLICY` = REPL_FIFO (1), a full cache evicts the slot filled earliest, and hits do not change that order.
- R11: A store miss fetches the line, merges the store bytes and marks the slot dirty. A later load returns the merged word, and a later eviction writes it back.
- R12: `cpu_ready` is 0 from the cycle after a miss is accepted until its response is given. `mem_req` is never 1 while `cpu_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Cache can accept a request this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address, 4-byte aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte lanes, bit i enables bits 8i+7..8i |
| cpu_rvalid | output | 1 | Response pulse for an accepted request |
| cpu_rdata | output | 32 | Load data (for a store, the word before the merge) |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = writeback beat, 0 = fill beat |
| mem_addr | output | 32 | Word address of the current beat |
| mem_wdata | output | 32 | Writeback data |
| mem_ack | input | 1 | Beat completes on this edge |
| mem_rdata | input | 32 | Fill data, valid while `mem_ack` is 1 |

## Verification
The bench drives the LRU instance through a precise recency sequence. A refreshed line must survive eviction, a previously dirty slot must be written back with its merged word, and the line installed over it must later leave silently. A design that ignored hits when updating recency, or that failed to clear the dirty flag on install, would show write beats or misses where none are expected. A second instance with oldest-fill order is hit repeatedly on its first line, which must still be evicted first. That instance also has to write back a dirty slot before a clean one of more recent use, exposing any policy mix-up. Each miss's beat log is compared word by word against the expected addresses and order, which catches a writeback placed after the fill, descending bursts, or misplaced store lanes.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } cache_state_e;

  typedef enum logic {
    REPL_LRU  = 1'b0,
    REPL_FIFO = 1'b1
  } repl_e;

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int SLOTS  = 8,
  parameter int TAG_W  = 27,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]       valid,
  input  logic [SLOTS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]       look_tag,
  output logic [SLOTS-1:0]       match_vec,
  output logic                   hit,
  output logic [SLOT_W-1:0]      hit_idx,
  output logic                   has_free,
  output logic [SLOT_W-1:0]      free_idx
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match_vec[g] = valid[g] && (tags[g*TAG_W +: TAG_W] == look_tag);
  end

  // lowest index wins for both encoders
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = SLOT_W'(i);
      if (!valid[i])    free_idx = SLOT_W'(i);
    end
  end

  assign hit      = |match_vec;
  assign has_free = ~&valid;

endmodule

// File: rtl/cache_repl.sv
module cache_repl #(
  parameter int              SLOTS  = 8,
  parameter int              SLOT_W = $clog2(SLOTS),
  parameter cache_pkg::repl_e POLICY = cache_pkg::REPL_LRU
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_en,
  input  logic [SLOT_W-1:0] use_idx,
  input  logic              fill_en,
  input  logic [SLOT_W-1:0] fill_idx,
  output logic [SLOT_W-1:0] victim
);

  logic              touch;
  logic [SLOT_W-1:0] touch_idx;
  logic [SLOT_W-1:0] rank_q [SLOTS];

  if (POLICY == cache_pkg::REPL_LRU) begin : g_lru
    assign touch     = use_en || fill_en;
    assign touch_idx = fill_en ? fill_idx : use_idx;
  end else begin : g_fifo
    logic unused_hits;
    assign unused_hits = use_en ^ (^use_idx);
    assign touch       = fill_en;
    assign touch_idx   = fill_idx;
  end

  // rank 0 = newest, SLOTS-1 = next to leave; ranks stay a permutation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) rank_q[i] <= SLOT_W'(SLOTS - 1 - i);
    end else if (touch) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (SLOT_W'(i) == touch_idx)          rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < SLOTS; i++)
      if (rank_q[i] == SLOT_W'(SLOTS - 1)) victim = SLOT_W'(i);
  end

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int SLOTS  = 8,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int WIDX_W = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic [SLOT_W-1:0]     rd_slot,
  input  logic [WIDX_W-1:0]     rd_word,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  wr_en,
  input  logic [SLOT_W-1:0]     wr_slot,
  input  logic [WIDX_W-1:0]     wr_word,
  input  logic [DATA_W/8-1:0]   wr_be,
  input  logic [DATA_W-1:0]     wr_data
);

  localparam int BYTES_W = DATA_W / 8;
  localparam int DEPTH   = SLOTS * WORDS;

  logic [DATA_W-1:0] line_mem [DEPTH];

  assign rd_data = line_mem[{rd_slot, rd_word}];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTES_W; b++)
        if (wr_be[b]) line_mem[{wr_slot, wr_word}][b*8 +: 8] <= wr_data[b*8 +: 8];
    end
  end

endmodule

// File: rtl/fa_wb_cache.sv
module fa_wb_cache #(
  parameter int               ADDR_W     = 32,
  parameter int               DATA_W     = 32,
  parameter int               LINE_BYTES = 32,
  parameter int               SLOTS      = 8,
  parameter cache_pkg::repl_e POLICY     = cache_pkg::REPL_LRU
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic                cpu_write,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  output logic                cpu_rvalid,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata
);
  import cache_pkg::*;

  localparam int BYTES_W = DATA_W / 8;
  localparam int LANE_W  = $clog2(BYTES_W);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int TAG_W   = ADDR_W - OFF_W;
  localparam int WORDS   = LINE_BYTES / BYTES_W;
  localparam int WIDX_W  = $clog2(WORDS);
  localparam int SLOT_W  = $clog2(SLOTS);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [WIDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:LANE_W];
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [TAG_W-1:0] t,
                                                 input logic [WIDX_W-1:0] k);
    return {t, k, {LANE_W{1'b0}}};
  endfunction

  cache_state_e         state;
  logic [WIDX_W-1:0]    beat;
  logic [SLOT_W-1:0]    vic;
  logic [TAG_W-1:0]     rq_tag;
  logic [WIDX_W-1:0]    rq_word;
  logic                 rq_we;
  logic [DATA_W-1:0]    rq_wdata;
  logic [BYTES_W-1:0]   rq_be;
  logic [SLOTS-1:0]     valid_q;
  logic [SLOTS-1:0]     dirty_q;
  logic [SLOTS*TAG_W-1:0] tag_q;
  logic                 rvalid_q;
  logic [DATA_W-1:0]    rdata_q;

  logic [SLOTS-1:0]     match_vec;
  logic                 hit;
  logic [SLOT_W-1:0]    hit_idx;
  logic                 has_free;
  logic [SLOT_W-1:0]    free_idx;
  logic [SLOT_W-1:0]    repl_victim;

  // named internal events, observed by the bound checker
  logic                 accept;
  logic                 hit_evt;
  logic                 miss_evt;
  logic                 last_beat;
  logic                 fill_done;
  logic [SLOT_W-1:0]    pick;
  logic                 need_wb;

  logic [SLOT_W-1:0]    rd_slot;
  logic [WIDX_W-1:0]    rd_word;
  logic [DATA_W-1:0]    rd_data;
  logic                 wr_en;
  logic [SLOT_W-1:0]    wr_slot;
  logic [WIDX_W-1:0]    wr_word;
  logic [BYTES_W-1:0]   wr_be;
  logic [DATA_W-1:0]    wr_data;

  logic unused_lane;
  assign unused_lane = ^cpu_addr[LANE_W-1:0];

  cache_tag_match #(.SLOTS(SLOTS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_match (
    .valid    (valid_q),
    .tags     (tag_q),
    .look_tag (tag_of(cpu_addr)),
    .match_vec(match_vec),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .has_free (has_free),
    .free_idx (free_idx)
  );

  assign cpu_ready = (state == ST_IDLE);
  assign accept    = cpu_valid && cpu_ready;
  assign hit_evt   = accept && hit;
  assign miss_evt  = accept && !hit;
  assign last_beat = (beat == WIDX_W'(WORDS - 1));
  assign fill_done = (state == ST_FILL) && mem_ack && last_beat;
  assign pick      = has_free ? free_idx : repl_victim;
  assign need_wb   = valid_q[pick] && dirty_q[pick];

  cache_repl #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .POLICY(POLICY)) u_repl (
    .clk     (clk),
    .rst_n   (rst_n),
    .use_en  (hit_evt),
    .use_idx (hit_idx),
    .fill_en (fill_done),
    .fill_idx(vic),
    .victim  (repl_victim)
  );

  always_comb begin
    unique case (state)
      ST_IDLE:  begin rd_slot = hit_idx; rd_word = word_of(cpu_addr); end
      ST_WBACK: begin rd_slot = vic;     rd_word = beat;              end
      default:  begin rd_slot = vic;     rd_word = rq_word;           end
    endcase
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_slot = vic;
    wr_word = rq_word;
    wr_be   = rq_be;
    wr_data = rq_wdata;
    unique case (state)
      ST_IDLE: begin
        wr_en   = hit_evt && cpu_write;
        wr_slot = hit_idx;
        wr_word = word_of(cpu_addr);
        wr_be   = cpu_be;
        wr_data = cpu_wdata;
      end
      ST_FILL: begin
        wr_en   = mem_ack;
        wr_word = beat;
        wr_be   = '1;
        wr_data = mem_rdata;
      end
      ST_RESP: wr_en = rq_we;
      default: wr_en = 1'b0;
    endcase
  end

  cache_line_store #(.SLOTS(SLOTS), .WORDS(WORDS), .DATA_W(DATA_W),
                     .SLOT_W(SLOT_W), .WIDX_W(WIDX_W)) u_store (
    .clk    (clk),
    .rd_slot(rd_slot),
    .rd_word(rd_word),
    .rd_data(rd_data),
    .wr_en  (wr_en),
    .wr_slot(wr_slot),
    .wr_word(wr_word),
    .wr_be  (wr_be),
    .wr_data(wr_data)
  );

  assign mem_req   = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = (state == ST_WBACK) ? beat_addr(tag_q[vic*TAG_W +: TAG_W], beat)
                                         : beat_addr(rq_tag, beat);
  assign mem_wdata = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat     <= '0;
      vic      <= '0;
      rq_tag   <= '0;
      rq_word  <= '0;
      rq_we    <= 1'b0;
      rq_wdata <= '0;
      rq_be    <= '0;
      valid_q  <= '0;
      dirty_q  <= '0;
      tag_q    <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (hit_evt) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_data;
            if (cpu_write) dirty_q[hit_idx] <= 1'b1;
          end else if (miss_evt) begin
            rq_tag   <= tag_of(cpu_addr);
            rq_word  <= word_of(cpu_addr);
            rq_we    <= cpu_write;
            rq_wdata <= cpu_wdata;
            rq_be    <= cpu_be;
            vic      <= pick;
            beat     <= '0;
            state    <= need_wb ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            beat <= beat + 1'b1;
            if (last_beat) state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            beat <= beat + 1'b1;
            if (last_beat) begin
              valid_q[vic]               <= 1'b1;
              dirty_q[vic]               <= 1'b0;
              tag_q[vic*TAG_W +: TAG_W]  <= rq_tag;
              state                      <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          rvalid_q <= 1'b1;
          rdata_q  <= rd_data;
          if (rq_we) dirty_q[vic] <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
  parameter int SLOTS  = 8,
  parameter int WIDX_W = 3,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [WIDX_W-1:0] beat_word,
  input logic [LANE_W-1:0] beat_lane,
  input logic [SLOTS-1:0]  match_vec,
  input logic              hit_evt,
  input logic              miss_evt,
  input logic              fill_done
);

  // R12: memory traffic only while the processor port is stalled
  assert_no_req_when_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  // R12: an accepted miss drops ready in the next cycle
  assert_miss_stalls_R12: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> !cpu_ready);

  // R2: a hit answers one cycle after acceptance
  assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> cpu_rvalid);

  // R4, R7: beats advance one word at a time in ascending order
  assert_burst_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && (beat_word != '1)) |=>
      (mem_req && (beat_word == $past(beat_word) + 1'b1)));

  // R4: beats are word aligned
  assert_beat_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (beat_lane == '0));

  // R4: the request is answered two cycles after the last fill beat
  assert_fill_then_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> ##1 cpu_rvalid);

  // R5: no line is resident in two slots
  assert_unique_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

endmodule

bind fa_wb_cache cache_checker #(.SLOTS(SLOTS), .WIDX_W(WIDX_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .cpu_rvalid(cpu_rvalid),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .beat_word (mem_addr[OFF_W-1:LANE_W]),
  .beat_lane (mem_addr[LANE_W-1:0]),
  .match_vec (match_vec),
  .hit_evt   (hit_evt),
  .miss_evt  (miss_evt),
  .fill_done (fill_done)
);

// File: tb/sim_fa_wb_cache.sv
module sim_fa_wb_cache;
  import cache_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic        cv [2];
  logic        cw [2];
  logic [31:0] ca [2];
  logic [31:0] cwd[2];
  logic [3:0]  cbe[2];
  logic        cr [2];
  logic        crv[2];
  logic [31:0] crd[2];
  logic        mreq[2];
  logic        mwe [2];
  logic [31:0] maddr[2];
  logic [31:0] mwd [2];
  logic        mack[2];
  logic [31:0] mrd [2];

  fa_wb_cache #(.POLICY(REPL_LRU)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[0]), .cpu_ready(cr[0]), .cpu_write(cw[0]),
    .cpu_addr(ca[0]), .cpu_wdata(cwd[0]), .cpu_be(cbe[0]), .cpu_rvalid(crv[0]),
    .cpu_rdata(crd[0]), .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]),
    .mem_wdata(mwd[0]), .mem_ack(mack[0]), .mem_rdata(mrd[0]));

  fa_wb_cache #(.POLICY(REPL_FIFO)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[1]), .cpu_ready(cr[1]), .cpu_write(cw[1]),
    .cpu_addr(ca[1]), .cpu_wdata(cwd[1]), .cpu_be(cbe[1]), .cpu_rvalid(crv[1]),
    .cpu_rdata(crd[1]), .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]),
    .mem_wdata(mwd[1]), .mem_ack(mack[1]), .mem_rdata(mrd[1]));

  // memory model: one beat every two cycles, beat log per instance
  logic [31:0] mem_m   [2][512];
  logic [31:0] shad    [2][512];
  logic [31:0] log_addr[2][1024];
  logic        log_we  [2][1024];
  int          log_n   [2];

  function automatic logic [31:0] init_word(input int i);
    return (32'h0100_0193 * (i + 7)) ^ 32'hA5C3_5A3C;
  endfunction

  function automatic logic [31:0] line_base(input int n);
    return 32'h4000_0000 | (n << 20) | (n << 5);
  endfunction

  function automatic int widx(input logic [31:0] a);
    return int'(a[10:2]);
  endfunction

  assign mrd[0] = mem_m[0][maddr[0][10:2]];
  assign mrd[1] = mem_m[1][maddr[1][10:2]];

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        mack[d]  <= 1'b0;
        log_n[d] <= 0;
        for (int i = 0; i < 512; i++) mem_m[d][i] <= init_word(i);
      end else begin
        mack[d] <= mreq[d] && !mack[d];
        if (mreq[d] && mack[d]) begin
          log_addr[d][log_n[d] % 1024] <= maddr[d];
          log_we[d][log_n[d] % 1024]   <= mwe[d];
          log_n[d] <= log_n[d] + 1;
          if (mwe[d]) mem_m[d][maddr[d][10:2]] <= mwd[d];
        end
      end
    end
  end

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one processor access; drives at negedges, samples at negedges
  task automatic access(input int d, input bit we, input logic [31:0] a,
                        input logic [31:0] wd, input logic [3:0] be,
                        output logic [31:0] rd, output int lat,
                        output bit stall, output int start);
    start = log_n[d];
    cv[d] = 1'b1; cw[d] = we; ca[d] = a; cwd[d] = wd; cbe[d] = be;
    while (!cr[d]) @(negedge clk);
    @(negedge clk);
    cv[d] = 1'b0;
    stall = !cr[d];
    lat = 0;
    while (!crv[d] && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    rd = crd[d];
    if (we) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) shad[d][widx(a)][b*8 +: 8] = wd[b*8 +: 8];
    end
  endtask

  function automatic bit traffic_ok(input int d, input int start, input int nw,
                                    input int wl, input int nr, input int rl);
    bit ok = (log_n[d] - start) == (nw + nr);
    for (int k = 0; k < nw + nr && ok; k++) begin
      int p = (start + k) % 1024;
      if (k < nw) ok = log_we[d][p] && (log_addr[d][p] == line_base(wl) + 32'(4 * k));
      else        ok = !log_we[d][p] && (log_addr[d][p] == line_base(rl) + 32'(4 * (k - nw)));
    end
    return ok;
  endfunction

  // load expected to hit: no beats, answer at once, data from shadow
  task automatic load_hit(input int d, input logic [31:0] a, input string req);
    logic [31:0] rd; int lat; bit st; int s;
    access(d, 1'b0, a, 32'h0, 4'h0, rd, lat, st, s);
    check((log_n[d] == s) && (lat == 0) && !st, req, "hit: beats/latency",
          32'(log_n[d] - s), 32'(lat));
    check(rd == shad[d][widx(a)], req, "hit load data", rd, shad[d][widx(a)]);
  endtask

  // load expected to miss with given traffic
  task automatic load_miss(input int d, input int line, input int nw, input int wl,
                           input string req);
    logic [31:0] rd; int lat; bit st; int s;
    logic [31:0] a = line_base(line) + 32'd12;
    access(d, 1'b0, a, 32'h0, 4'h0, rd, lat, st, s);
    check(traffic_ok(d, s, nw, wl, 8, line), req, "miss beat sequence",
          32'(log_n[d] - s), 32'(nw + 8));
    check(st, "R12", "ready low after miss accept", 32'(st), 32'd1);
    check(rd == shad[d][widx(a)], req, "miss load data", rd, shad[d][widx(a)]);
  endtask

  function automatic bit line_in_mem(input int d, input int line);
    bit ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      int i = widx(line_base(line)) + k;
      if (mem_m[d][i] != shad[d][i]) ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic t_reset();
    check(cr[0] && cr[1], "R1", "ready after reset", 32'(cr[0]), 32'd1);
    check(!crv[0] && !crv[1], "R1", "rvalid after reset", 32'(crv[0]), 32'd0);
    check(!mreq[0] && !mreq[1], "R1", "mem_req after reset", 32'(mreq[0]), 32'd0);
  endtask

  task automatic t_cold_then_hit();
    load_miss(0, 0, 0, 0, "R1 R4");
    load_hit(0, line_base(0) + 32'd12, "R2");
  endtask

  task automatic t_store_hit();
    logic [31:0] rd; int lat; bit st; int s;
    logic [31:0] a = line_base(0) + 32'd12;
    access(0, 1'b1, a, 32'hDEAD_BEEF, 4'b0101, rd, lat, st, s);
    check((log_n[0] == s) && (lat == 0), "R3", "store hit without beats",
          32'(log_n[0] - s), 32'd0);
    load_hit(0, a, "R3");
    check(mem_m[0][widx(a)] == init_word(widx(a)), "R3", "memory untouched by store hit",
          mem_m[0][widx(a)], init_word(widx(a)));
    load_hit(0, line_base(0) + 32'd16, "R3");
  endtask

  task automatic t_fill_free();
    for (int n = 1; n < 8; n++) load_miss(0, n, 0, 0, "R5");
    for (int n = 0; n < 8; n++) load_hit(0, line_base(n) + 32'd4, "R5");
    load_hit(0, line_base(0), "R9");
  endtask

  task automatic t_lru_clean();
    load_miss(0, 8, 0, 0, "R6 R9");
    load_hit(0, line_base(0) + 32'd12, "R9");
    for (int n = 2; n < 9; n++) load_hit(0, line_base(n), "R9");
  endtask

  task automatic t_dirty_wb();
    load_miss(0, 9, 8, 0, "R7");
    check(line_in_mem(0, 0), "R7", "written-back line in memory", 32'd0, 32'd1);
    check(mem_m[0][widx(line_base(0)) + 3] == shad[0][widx(line_base(0)) + 3], "R3",
          "merged word reached memory on eviction",
          mem_m[0][widx(line_base(0)) + 3], shad[0][widx(line_base(0)) + 3]);
  endtask

  task automatic t_store_miss();
    logic [31:0] rd; int lat; bit st; int s;
    logic [31:0] a = line_base(10) + 32'd20;
    access(0, 1'b1, a, 32'h0BAD_F00D, 4'b1111, rd, lat, st, s);
    check(traffic_ok(0, s, 0, 0, 8, 10), "R11", "store miss fetches line",
          32'(log_n[0] - s), 32'd8);
    check(mem_m[0][widx(a)] == init_word(widx(a)), "R11", "store miss leaves memory",
          mem_m[0][widx(a)], init_word(widx(a)));
    load_hit(0, a, "R11");
  endtask

  task automatic t_clean_install();
    for (int n = 3; n < 9; n++) load_hit(0, line_base(n), "R9");
    load_miss(0, 11, 0, 0, "R8");
  endtask

  task automatic t_alloc_wb();
    load_miss(0, 12, 8, 10, "R11");
    check(mem_m[0][widx(line_base(10)) + 5] == 32'h0BAD_F00D, "R11",
          "allocated store written back", mem_m[0][widx(line_base(10)) + 5], 32'h0BAD_F00D);
  endtask

  task automatic t_fifo();
    logic [31:0] rd; int lat; bit st; int s;
    for (int n = 0; n < 8; n++) load_miss(1, n, 0, 0, "R5");
    access(1, 1'b1, line_base(2), 32'h1234_5678, 4'b1111, rd, lat, st, s);
    check(log_n[1] == s, "R3", "FIFO instance store hit", 32'(log_n[1] - s), 32'd0);
    for (int r = 0; r < 3; r++) load_hit(1, line_base(0) + 32'd8, "R10");
    load_miss(1, 8, 0, 0, "R10");
    load_hit(1, line_base(1), "R10");
    load_miss(1, 0, 0, 0, "R10");
    load_miss(1, 9, 8, 2, "R10 R7");
    check(line_in_mem(1, 2), "R10", "FIFO victim written back", 32'd0, 32'd1);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      cv[d] = 1'b0; cw[d] = 1'b0; ca[d] = '0; cwd[d] = '0; cbe[d] = '0;
      for (int i = 0; i < 512; i++) shad[d][i] = init_word(i);
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_then_hit();
    t_store_hit();
    t_fill_free();
    t_lru_clean();
    t_dirty_wb();
    t_store_miss();
    t_clean_install();
    t_alloc_wb();
    t_fifo();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

endmodule